// File: doc/BRIEF.md
# Single-Vector Trap Entry Unit

This block holds the exception and privilege state of one 32-bit core and performs trap entry and return. At each instruction boundary the pipeline presents the PC of the instruction about to execute. The block then takes one of four actions: it takes a pending hardware interrupt, takes a synchronous fault, performs a return from trap, or lets the instruction proceed. Every trap goes to a single entry address, which is held in a software-written vector register.

On a trap, the block saves the previous privilege mode and interrupt enable into a two-bit saved-status register. It records the instruction PC, the cause code and the fault address, then enters privileged mode with interrupts off. In the following cycle it raises a one-cycle redirect strobe, with the next PC set to the vector. A return from trap restores mode and enable from the saved status and redirects to the saved PC. Software can write the vector, scratch and saved-status registers.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, pc_next, vec, epc, cause, badaddr, estatus and scratch read zero, mode_user is 0 (privileged), irq_en is 0 and redirect is 0.
- R2: On trap entry, estatus bit 0 takes the interrupt enable and bit 1 takes the mode (0 privileged, 1 user) as they stood in the cycle of the trap.
- R3: On trap entry, epc takes issue_pc of that cycle, which is the PC of the interrupted or faulting instruction and not the next sequential PC.
- R4: On a fault trap, cause takes fault_cause and badaddr takes fault_addr. On an interrupt trap, cause takes the parameter IRQ_CAUSE and badaddr takes zero.
- R5: In the cycle after trap entry, mode_user is 0, irq_en is 0, redirect is 1, and pc_next equals the vector value held before the trap edge.
- R6: An interrupt is taken only in a cycle where issue_valid, irq_pending and irq_en are all 1. In any other cycle, irq_pending changes no output and irq_ack stays 0.
- R7: irq_ack is 1, combinationally, exactly in the cycle an interrupt is taken. A taken interrupt beats a fault and a return request presented in the same cycle.
- R8: A return request (ret_req) without a same-cycle trap sets mode_user from estatus bit 1 and irq_en from estatus bit 0, and redirects to epc in the next cycle. A fault in the same cycle beats the return.
- R9: estatus bits 31:2 always read zero. status_we stores status_wdata into bits 1:0, except in a trap cycle, where the trap value wins.
- R10: vec_we and scratch_we update vec and scratch in the next cycle. A trap in the same cycle as a vec write redirects to the old vector.
- R11: redirect is 0 in every cycle that does not follow a trap or a return, and pc_next then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction boundary is present this cycle |
| issue_pc | input | 32 | PC of the instruction about to execute or faulting |
| fault_req | input | 1 | Synchronous fault request |
| fault_cause | input | CAUSE_W | Fault cause code (never IRQ_CAUSE) |
| fault_addr | input | 32 | Faulting address |
| irq_pending | input | 1 | External interrupt pending |
| irq_ack | output | 1 | Interrupt taken this cycle |
| ret_req | input | 1 | Return-from-trap request |
| vec_we | input | 1 | Vector register write enable |
| vec_wdata | input | 32 | Vector write data |
| scratch_we | input | 1 | Scratch register write enable |
| scratch_wdata | input | 32 | Scratch write data |
| status_we | input | 1 | Saved-status write enable |
| status_wdata | input | 2 | Saved-status write data {mode, enable} |
| pc_next | output | 32 | Redirect target PC |
| redirect | output | 1 | One-cycle redirect strobe |
| mode_user | output | 1 | Current mode, 1 = user |
| irq_en | output | 1 | Current interrupt enable |
| epc | output | 32 | Saved exception PC |
| cause | output | CAUSE_W | Trap cause |
| badaddr | output | 32 | Fault address |
| estatus | output | 32 | Saved status, bits 1:0 used |
| vec | output | 32 | Trap entry vector |
| scratch | output | 32 | Software scratch |

## Verification
The bench targets the following collisions:
- **Interrupt and fault in the same cycle.** A design that lets the fault win records the wrong cause and a nonzero badaddr.
- **Masked interrupt.** A design that samples the interrupt while it is masked, or off a boundary, traps when it should not and raises irq_ack.
- **Vector write in the trap cycle.** A design that forwards the new vector redirects to the wrong target.
- **Status write in the trap cycle.** A design that lets the write win loses the saved mode.
- **Return.** A design that returns to the next sequential PC, or swaps the two status bits, leaves the wrong mode and enable after the return.

A long random phase then compares every output against a behavioural model on every clock.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_IRQ   = 2'd1,
    EV_FAULT = 2'd2,
    EV_RET   = 2'd3
  } trap_ev_e;

  // Saved status layout: bit 1 = mode (1 user), bit 0 = interrupt enable.
  function automatic logic [1:0] pack_status(input logic user, input logic ie);
    return {user, ie};
  endfunction

  function automatic logic status_user(input logic [1:0] st);
    return st[1];
  endfunction

  function automatic logic status_ie(input logic [1:0] st);
    return st[0];
  endfunction

  function automatic logic is_trap(input trap_ev_e ev);
    return (ev == EV_IRQ) || (ev == EV_FAULT);
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic     issue_valid,
  input  logic     irq_pending,
  input  logic     irq_en,
  input  logic     fault_req,
  input  logic     ret_req,
  output trap_ev_e ev,
  output logic     irq_take
);

  always_comb begin
    irq_take = issue_valid && irq_pending && irq_en;
    if (irq_take)       ev = EV_IRQ;
    else if (fault_req) ev = EV_FAULT;
    else if (ret_req)   ev = EV_RET;
    else                ev = EV_NONE;
  end

endmodule

// File: rtl/trap_priv_state.sv
module trap_priv_state
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trap_ev_e   ev,
  input  logic       status_we,
  input  logic [1:0] status_wdata,
  output logic       mode_user,
  output logic       irq_en,
  output logic [1:0] saved_st
);

  logic trap_now;
  logic ret_now;
  assign trap_now = is_trap(ev);
  assign ret_now  = (ev == EV_RET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_user <= 1'b0;
      irq_en    <= 1'b0;
      saved_st  <= 2'b00;
    end else if (trap_now) begin
      saved_st  <= pack_status(mode_user, irq_en);
      mode_user <= 1'b0;
      irq_en    <= 1'b0;
    end else begin
      if (ret_now) begin
        mode_user <= status_user(saved_st);
        irq_en    <= status_ie(saved_st);
      end
      if (status_we) saved_st <= status_wdata;
    end
  end

  assert_trap_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> (!mode_user && !irq_en));

  assert_trap_pack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> (saved_st[1] == $past(mode_user) && saved_st[0] == $past(irq_en)));

  assert_ret_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_now |=> (mode_user == $past(saved_st[1]) && irq_en == $past(saved_st[0])));

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
  import trap_pkg::*;
#(
  parameter int unsigned           XLEN      = 32,
  parameter int unsigned           CAUSE_W   = 8,
  parameter logic [CAUSE_W-1:0]    IRQ_CAUSE = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  trap_ev_e           ev,
  input  logic [XLEN-1:0]    issue_pc,
  input  logic [CAUSE_W-1:0] fault_cause,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic               vec_we,
  input  logic [XLEN-1:0]    vec_wdata,
  input  logic               scratch_we,
  input  logic [XLEN-1:0]    scratch_wdata,
  output logic [XLEN-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    badaddr,
  output logic [XLEN-1:0]    vec,
  output logic [XLEN-1:0]    scratch,
  output logic [XLEN-1:0]    pc_next,
  output logic               redirect
);

  logic trap_now;
  logic irq_now;
  logic ret_now;
  assign trap_now = is_trap(ev);
  assign irq_now  = (ev == EV_IRQ);
  assign ret_now  = (ev == EV_RET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc      <= '0;
      cause    <= '0;
      badaddr  <= '0;
      pc_next  <= '0;
      redirect <= 1'b0;
    end else begin
      redirect <= trap_now || ret_now;
      if (trap_now) begin
        epc     <= issue_pc;
        cause   <= irq_now ? IRQ_CAUSE : fault_cause;
        badaddr <= irq_now ? '0 : fault_addr;
        pc_next <= vec;
      end else if (ret_now) begin
        pc_next <= epc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec     <= '0;
      scratch <= '0;
    end else begin
      if (vec_we)     vec     <= vec_wdata;
      if (scratch_we) scratch <= scratch_wdata;
    end
  end

  assert_trap_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> (epc == $past(issue_pc)));

  assert_trap_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> (redirect && pc_next == $past(vec)));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_now |=> (cause == IRQ_CAUSE && badaddr == '0));

  assert_ret_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_now |=> (redirect && pc_next == $past(epc)));

  assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_NONE) |=> (!redirect && $stable(pc_next)));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned        XLEN      = 32,
  parameter int unsigned        CAUSE_W   = 8,
  parameter logic [CAUSE_W-1:0] IRQ_CAUSE = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic [XLEN-1:0]    issue_pc,
  input  logic               fault_req,
  input  logic [CAUSE_W-1:0] fault_cause,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic               irq_pending,
  output logic               irq_ack,
  input  logic               ret_req,
  input  logic               vec_we,
  input  logic [XLEN-1:0]    vec_wdata,
  input  logic               scratch_we,
  input  logic [XLEN-1:0]    scratch_wdata,
  input  logic               status_we,
  input  logic [1:0]         status_wdata,
  output logic [XLEN-1:0]    pc_next,
  output logic               redirect,
  output logic               mode_user,
  output logic               irq_en,
  output logic [XLEN-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    badaddr,
  output logic [XLEN-1:0]    estatus,
  output logic [XLEN-1:0]    vec,
  output logic [XLEN-1:0]    scratch
);

  localparam int unsigned PAD_W = XLEN - 2;

  trap_ev_e   ev;
  logic       irq_take;
  logic [1:0] saved_st;

  trap_arbiter u_arb (
    .issue_valid (issue_valid),
    .irq_pending (irq_pending),
    .irq_en      (irq_en),
    .fault_req   (fault_req),
    .ret_req     (ret_req),
    .ev          (ev),
    .irq_take    (irq_take)
  );

  trap_priv_state u_priv (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev           (ev),
    .status_we    (status_we),
    .status_wdata (status_wdata),
    .mode_user    (mode_user),
    .irq_en       (irq_en),
    .saved_st     (saved_st)
  );

  trap_csr_file #(
    .XLEN      (XLEN),
    .CAUSE_W   (CAUSE_W),
    .IRQ_CAUSE (IRQ_CAUSE)
  ) u_csr (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev            (ev),
    .issue_pc      (issue_pc),
    .fault_cause   (fault_cause),
    .fault_addr    (fault_addr),
    .vec_we        (vec_we),
    .vec_wdata     (vec_wdata),
    .scratch_we    (scratch_we),
    .scratch_wdata (scratch_wdata),
    .epc           (epc),
    .cause         (cause),
    .badaddr       (badaddr),
    .vec           (vec),
    .scratch       (scratch),
    .pc_next       (pc_next),
    .redirect      (redirect)
  );

  assign irq_ack = irq_take;
  assign estatus = {{PAD_W{1'b0}}, saved_st};

  // R6: the interrupt is never acknowledged while masked by the state module.
  assert_masked_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_ack);

  // R7: an acknowledged interrupt records the interrupt cause, even against a fault.
  assert_irq_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && fault_req) |=> (cause == IRQ_CAUSE));

  // R9: upper saved-status bits stay zero.
  assert_status_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    estatus[XLEN-1:2] == '0);

  // R4: fault codes never collide with the interrupt code.
  assert_cause_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> (fault_cause != IRQ_CAUSE));

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;

  localparam logic [7:0] IRQC = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid, fault_req, irq_pending, ret_req;
  logic        vec_we, scratch_we, status_we;
  logic [31:0] issue_pc, fault_addr, vec_wdata, scratch_wdata;
  logic [7:0]  fault_cause;
  logic [1:0]  status_wdata;
  logic        irq_ack, redirect, mode_user, irq_en;
  logic [31:0] pc_next, epc, badaddr, estatus, vec, scratch;
  logic [7:0]  cause;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  bit        m_user, m_ie, m_red;
  bit [1:0]  m_st;
  bit [31:0] m_epc, m_bad, m_vec, m_scr, m_pcn;
  bit [7:0]  m_cause;

  trap_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_pc(issue_pc),
    .fault_req(fault_req), .fault_cause(fault_cause), .fault_addr(fault_addr),
    .irq_pending(irq_pending), .irq_ack(irq_ack), .ret_req(ret_req),
    .vec_we(vec_we), .vec_wdata(vec_wdata), .scratch_we(scratch_we),
    .scratch_wdata(scratch_wdata), .status_we(status_we), .status_wdata(status_wdata),
    .pc_next(pc_next), .redirect(redirect), .mode_user(mode_user), .irq_en(irq_en),
    .epc(epc), .cause(cause), .badaddr(badaddr), .estatus(estatus),
    .vec(vec), .scratch(scratch)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    issue_valid = 0; fault_req = 0; irq_pending = 0; ret_req = 0;
    vec_we = 0; scratch_we = 0; status_we = 0;
    issue_pc = 0; fault_addr = 0; fault_cause = 0;
    vec_wdata = 0; scratch_wdata = 0; status_wdata = 0;
  endtask

  function automatic bit model_irq();
    return issue_valid && irq_pending && m_ie;
  endfunction

  task automatic compare_all(input string tag);
    chk(tag, "pc_next", pc_next, m_pcn);
    chk(tag, "redirect", 32'(redirect), 32'(m_red));
    chk(tag, "mode_user", 32'(mode_user), 32'(m_user));
    chk(tag, "irq_en", 32'(irq_en), 32'(m_ie));
    chk(tag, "epc", epc, m_epc);
    chk(tag, "cause", 32'(cause), 32'(m_cause));
    chk(tag, "badaddr", badaddr, m_bad);
    chk(tag, "estatus", estatus, {30'd0, m_st});
    chk(tag, "vec", vec, m_vec);
    chk(tag, "scratch", scratch, m_scr);
  endtask

  // One clock: inputs already driven after a negedge.
  task automatic cyc(input string tag);
    bit ti, tf, tr;
    #1;
    ti = model_irq();
    chk(tag, "irq_ack", 32'(irq_ack), 32'(ti));
    @(posedge clk);
    tf = !ti && fault_req;
    tr = !ti && !tf && ret_req;
    if (ti || tf) begin
      m_st = {m_user, m_ie};
      m_epc = issue_pc;
      m_cause = ti ? IRQC : fault_cause;
      m_bad = ti ? 32'd0 : fault_addr;
      m_user = 0; m_ie = 0;
      m_pcn = m_vec; m_red = 1;
    end else begin
      if (tr) begin
        m_user = m_st[1]; m_ie = m_st[0];
        m_pcn = m_epc; m_red = 1;
      end else m_red = 0;
      if (status_we) m_st = status_wdata;
    end
    if (vec_we) m_vec = vec_wdata;
    if (scratch_we) m_scr = scratch_wdata;
    @(negedge clk);
    compare_all(tag);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    m_user = 0; m_ie = 0; m_red = 0; m_st = 0;
    m_epc = 0; m_bad = 0; m_vec = 0; m_scr = 0; m_pcn = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_all("R1");

    // R10: vector and scratch writes
    vec_we = 1; vec_wdata = 32'h100; scratch_we = 1; scratch_wdata = 32'hABCD;
    cyc("R10");

    // R6: masked interrupt ignored
    issue_valid = 1; issue_pc = 32'h20; irq_pending = 1;
    cyc("R6");

    // R3 R4 R5 R2: fault trap from privileged, IE off
    issue_valid = 1; issue_pc = 32'h40; fault_req = 1; fault_cause = 8'd3;
    fault_addr = 32'h1234;
    cyc("R3");
    chk("R4", "cause", 32'(cause), 32'd3);
    chk("R5", "pc_next", pc_next, 32'h100);
    cyc("R11");

    // R9: status write keeps only two bits
    status_we = 1; status_wdata = 2'b11;
    cyc("R9");
    chk("R9", "estatus", estatus, 32'h3);

    // R8: return to user with IE
    ret_req = 1;
    cyc("R8");
    chk("R8", "mode_user", 32'(mode_user), 32'd1);
    chk("R8", "pc_next", pc_next, 32'h40);

    // R6: interrupt pending but no boundary
    irq_pending = 1; issue_valid = 0;
    cyc("R6");

    // R7: interrupt beats fault, ack same cycle
    issue_valid = 1; issue_pc = 32'h80; irq_pending = 1; fault_req = 1;
    fault_cause = 8'd5; fault_addr = 32'hDEAD;
    cyc("R7");
    chk("R7", "badaddr", badaddr, 32'd0);
    chk("R2", "estatus", estatus, 32'h3);

    // R9: status write in a trap cycle loses; R10: vec write uses old vector
    status_we = 1; status_wdata = 2'b11; ret_req = 1;
    cyc("R8");
    issue_valid = 1; issue_pc = 32'h90; fault_req = 1; fault_cause = 8'd7;
    vec_we = 1; vec_wdata = 32'h200; status_we = 1; status_wdata = 2'b00;
    cyc("R10");
    chk("R10", "pc_next", pc_next, 32'h100);
    chk("R9", "estatus", estatus, 32'h3);

    // R8: fault beats return
    fault_req = 1; ret_req = 1; issue_pc = 32'hA0; fault_cause = 8'd2;
    cyc("R8");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      issue_valid = $urandom_range(0, 1) == 1;
      issue_pc = $urandom;
      irq_pending = $urandom_range(0, 2) == 0;
      fault_req = $urandom_range(0, 5) == 0;
      fault_cause = 8'($urandom_range(0, 63));
      fault_addr = $urandom;
      ret_req = $urandom_range(0, 4) == 0;
      vec_we = $urandom_range(0, 7) == 0;
      vec_wdata = $urandom;
      scratch_we = $urandom_range(0, 7) == 0;
      scratch_wdata = $urandom;
      status_we = $urandom_range(0, 4) == 0;
      status_wdata = 2'($urandom_range(0, 3));
      cyc("R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule